// File: doc/BRIEF.md
# Tunneled Packet HopID Router

This block forwards transport-layer tunneled packets from a set of ingress adapters toward egress adapters. Every ingress adapter owns a private routing table. The table is indexed by the HopID that a packet carries when it arrives. A valid entry gives two things: the egress adapter the packet must leave on, and the HopID that replaces the incoming one. The label therefore changes at every hop. The router never inspects which native protocol a packet belongs to. Streams that share the router, such as the fixed HopID 8 and HopID 9 channels of the protocol adapters, are told apart only by their (ingress adapter, HopID) pair.

An external manager fills the tables through a single-cycle write port. Packets arrive as beats on a valid/ready stream, and `in_last_i` marks the final beat. The first beat of a packet is its header. The lookup happens on the header, and the later beats of the packet follow the header's decision. A header with no valid entry causes the whole packet to be consumed and discarded. The router then records the loss in a sticky flag and in a saturating counter. Forwarded beats leave through one output register.

Top module: `hop_router`

## Requirements
- R1: After reset, `out_valid_o`=0, `in_ready_o`=1, `miss_flag_o`=0 and `miss_cnt_o`=0. Every table entry is invalid, so the first header after reset is dropped.
- R2: A header accepted on ingress `a` with HopID `h` whose entry is valid produces one output beat in the following cycle. That beat has `out_egr_o` equal to the programmed egress adapter and `out_hop_o` equal to the programmed replacement HopID, and it keeps the same data and last flag.
- R3: Tables are per ingress adapter. The same HopID (for example 8 or 9) arriving on different adapters resolves through each adapter's own entry.
- R4: A header whose entry is invalid, or whose HopID is at or above `TBL_DEPTH`, causes every beat of that packet up to and including its last beat to be accepted and discarded. None of those beats reaches the output.
- R5: Each dropped packet raises `miss_cnt_o` by exactly one, and the counter saturates at all ones. `miss_flag_o` goes to 1 on the first drop and stays at 1 until reset.
- R6: Non-header beats carry the header's egress adapter and rewritten HopID. Their own `in_ing_i` and `in_hop_i` values have no effect.
- R7: A table write in cycle t applies to headers accepted from cycle t+1 onward. A header accepted in cycle t itself sees the old contents.
- R8: A later write to the same (ingress, HopID) pair replaces the earlier one. A write with `cfg_vld_i`=0 removes the entry.
- R9: `in_ready_o` is 0 exactly when `out_valid_o`=1 and `out_ready_i`=0. While the output stalls, all of its fields stay stable.
- R10: Forwarded beats leave in the order they were accepted. No beat is duplicated or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_ing_i | input | ING_W | Ingress adapter whose table is written |
| cfg_hop_i | input | 11 | Incoming HopID (entry index) |
| cfg_vld_i | input | 1 | Entry valid bit to store |
| cfg_egr_i | input | 6 | Egress adapter to store |
| cfg_new_hop_i | input | 11 | Replacement HopID to store |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_ing_i | input | ING_W | Ingress adapter of the packet (header beat) |
| in_hop_i | input | 11 | Incoming HopID (header beat) |
| in_last_i | input | 1 | Final beat of packet |
| in_data_i | input | DATA_W | Beat payload |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts output beat |
| out_egr_o | output | 6 | Selected egress adapter |
| out_hop_o | output | 11 | Rewritten HopID |
| out_last_o | output | 1 | Final beat of packet |
| out_data_o | output | DATA_W | Beat payload |
| miss_flag_o | output | 1 | Sticky: a packet has been dropped |
| miss_cnt_o | output | MISS_CNT_W | Saturating count of dropped packets |

## Verification
Directed traffic sends HopID 8 and 9 on several adapters. This separates per-adapter tables from one shared table, and it shows whether a hop rewrite lands on the proper stream. A write issued in the same cycle as a matching header, and then again one cycle later, shows exactly when a write takes effect. Overwrite and invalidate sequences, together with out-of-range HopIDs inside multi-beat packets, show whether drop decisions cover the whole packet. A long burst of misses drives the counter into saturation. Random packets of mixed lengths, with random back-pressure and random table writes interleaved, are compared beat by beat against a reference model of the tables. This catches ordering, stall-stability and continuation-beat faults.

// File: rtl/hop_router_pkg.sv
package hop_router_pkg;
  localparam int HOP_W  = 11;
  localparam int ADPT_W = 6;

  typedef logic [HOP_W-1:0]  hop_t;
  typedef logic [ADPT_W-1:0] adpt_t;

  typedef struct packed {
    logic  vld;
    adpt_t egr;
    hop_t  hop;
  } route_t;
endpackage

// File: rtl/hop_route_table.sv
module hop_route_table
  import hop_router_pkg::*;
#(
  parameter  int NUM_ING   = 4,
  parameter  int TBL_DEPTH = 16,
  localparam int ING_W     = (NUM_ING > 1) ? $clog2(NUM_ING) : 1,
  localparam int IDX_W     = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ING_W-1:0] wr_ing_i,
  input  hop_t             wr_hop_i,
  input  route_t           wr_ent_i,
  input  logic [ING_W-1:0] rd_ing_i,
  input  hop_t             rd_hop_i,
  output route_t           rd_ent_o
);
  localparam logic [HOP_W:0] DEPTH_L = (HOP_W+1)'(TBL_DEPTH);

  logic   wr_in_range, rd_in_range;
  route_t rd_bank [NUM_ING];

  assign wr_in_range = ({1'b0, wr_hop_i} < DEPTH_L);
  assign rd_in_range = ({1'b0, rd_hop_i} < DEPTH_L);

  for (genvar g = 0; g < NUM_ING; g++) begin : g_bank
    route_t mem_q [TBL_DEPTH];
    logic   wr_sel;

    assign wr_sel = wr_en_i && wr_in_range && (wr_ing_i == ING_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < TBL_DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_sel) begin
        mem_q[wr_hop_i[IDX_W-1:0]] <= wr_ent_i;
      end
    end

    assign rd_bank[g] = mem_q[rd_hop_i[IDX_W-1:0]];
  end

  // out-of-range hop or adapter reads as an invalid entry
  always_comb begin
    rd_ent_o = '0;
    if (rd_in_range && (int'(rd_ing_i) < NUM_ING)) rd_ent_o = rd_bank[rd_ing_i];
  end
endmodule

// File: rtl/hop_frame_ctl.sv
module hop_frame_ctl
  import hop_router_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fire_i,
  input  logic   last_i,
  input  route_t lkp_i,
  output logic   fwd_o,
  output adpt_t  egr_o,
  output hop_t   hop_o,
  output logic   miss_o
);
  logic  mid_q, drop_q, hdr;
  adpt_t egr_q;
  hop_t  hop_q;

  assign hdr    = !mid_q;
  assign fwd_o  = hdr ? lkp_i.vld : !drop_q;
  assign egr_o  = hdr ? lkp_i.egr : egr_q;
  assign hop_o  = hdr ? lkp_i.hop : hop_q;
  assign miss_o = fire_i && hdr && !lkp_i.vld;

  // route decided on header is held for the rest of the packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q  <= 1'b0;
      drop_q <= 1'b0;
      egr_q  <= '0;
      hop_q  <= '0;
    end else if (fire_i) begin
      mid_q <= !last_i;
      if (hdr) begin
        drop_q <= !lkp_i.vld;
        egr_q  <= lkp_i.egr;
        hop_q  <= lkp_i.hop;
      end
    end
  end
endmodule

// File: rtl/hop_out_stage.sv
module hop_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign ready_o = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (load_i)       valid_q <= 1'b1;
      else if (ready_i) valid_q <= 1'b0;
      if (load_i) data_q <= data_i;
    end
  end
endmodule

// File: rtl/hop_miss_stats.sv
module hop_miss_stats #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;

  assign flag_o = flag_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (miss_i) begin
      flag_q <= 1'b1;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hop_router.sv
module hop_router
  import hop_router_pkg::*;
#(
  parameter  int NUM_ING    = 4,
  parameter  int TBL_DEPTH  = 16,
  parameter  int DATA_W     = 32,
  parameter  int MISS_CNT_W = 8,
  localparam int ING_W      = (NUM_ING > 1) ? $clog2(NUM_ING) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [ING_W-1:0]      cfg_ing_i,
  input  logic [HOP_W-1:0]      cfg_hop_i,
  input  logic                  cfg_vld_i,
  input  logic [ADPT_W-1:0]     cfg_egr_i,
  input  logic [HOP_W-1:0]      cfg_new_hop_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [ING_W-1:0]      in_ing_i,
  input  logic [HOP_W-1:0]      in_hop_i,
  input  logic                  in_last_i,
  input  logic [DATA_W-1:0]     in_data_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [ADPT_W-1:0]     out_egr_o,
  output logic [HOP_W-1:0]      out_hop_o,
  output logic                  out_last_o,
  output logic [DATA_W-1:0]     out_data_o,
  output logic                  miss_flag_o,
  output logic [MISS_CNT_W-1:0] miss_cnt_o
);
  localparam int ST_W = ADPT_W + HOP_W + 1 + DATA_W;

  route_t          wr_ent, lkp;
  logic            st_ready, in_fire, fwd, miss;
  adpt_t           egr;
  hop_t            hop;
  logic [ST_W-1:0] st_data;

  assign wr_ent     = '{vld: cfg_vld_i, egr: cfg_egr_i, hop: cfg_new_hop_i};
  assign in_ready_o = st_ready;
  assign in_fire    = in_valid_i && st_ready;

  hop_route_table #(
    .NUM_ING  (NUM_ING),
    .TBL_DEPTH(TBL_DEPTH)
  ) i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_we_i),
    .wr_ing_i(cfg_ing_i),
    .wr_hop_i(cfg_hop_i),
    .wr_ent_i(wr_ent),
    .rd_ing_i(in_ing_i),
    .rd_hop_i(in_hop_i),
    .rd_ent_o(lkp)
  );

  hop_frame_ctl i_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(in_fire),
    .last_i(in_last_i),
    .lkp_i (lkp),
    .fwd_o (fwd),
    .egr_o (egr),
    .hop_o (hop),
    .miss_o(miss)
  );

  hop_out_stage #(
    .W(ST_W)
  ) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_fire && fwd),
    .data_i ({egr, hop, in_last_i, in_data_i}),
    .ready_o(st_ready),
    .valid_o(out_valid_o),
    .ready_i(out_ready_i),
    .data_o (st_data)
  );

  assign {out_egr_o, out_hop_o, out_last_o, out_data_o} = st_data;

  hop_miss_stats #(
    .CNT_W(MISS_CNT_W)
  ) i_stats (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .miss_i(miss),
    .flag_o(miss_flag_o),
    .cnt_o (miss_cnt_o)
  );
endmodule

// File: rtl/hop_router_chk.sv
module hop_router_chk #(
  parameter int DATA_W     = 32,
  parameter int MISS_CNT_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic                  out_valid_o,
  input logic                  out_ready_i,
  input logic [5:0]            out_egr_o,
  input logic [10:0]           out_hop_o,
  input logic                  out_last_o,
  input logic [DATA_W-1:0]     out_data_o,
  input logic                  miss_flag_o,
  input logic [MISS_CNT_W-1:0] miss_cnt_o
);
  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_egr_o) && $stable(out_hop_o)
      && $stable(out_last_o) && $stable(out_data_o)));

  // R9
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R5
  miss_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_flag_o |=> miss_flag_o);

  // R5
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

  // R5
  miss_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != '0) |-> miss_flag_o);

  // R2
  out_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));
endmodule

bind hop_router hop_router_chk #(
  .DATA_W    (DATA_W),
  .MISS_CNT_W(MISS_CNT_W)
) i_hop_router_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_egr_o  (out_egr_o),
  .out_hop_o  (out_hop_o),
  .out_last_o (out_last_o),
  .out_data_o (out_data_o),
  .miss_flag_o(miss_flag_o),
  .miss_cnt_o (miss_cnt_o)
);

// File: tb/test_hop_router.sv
module test_hop_router;
  localparam int CLK_PERIOD = 10;
  localparam int NI    = 4;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int CW    = 8;
  localparam int CMAX  = 255;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0, cfg_vld_i = 1'b0;
  logic [1:0]    cfg_ing_i = '0;
  logic [10:0]   cfg_hop_i = '0, cfg_new_hop_i = '0;
  logic [5:0]    cfg_egr_i = '0;
  logic          in_valid_i = 1'b0, in_last_i = 1'b0, out_ready_i = 1'b0;
  logic [1:0]    in_ing_i = '0;
  logic [10:0]   in_hop_i = '0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_ready_o, out_valid_o, out_last_o, miss_flag_o;
  logic [5:0]    out_egr_o;
  logic [10:0]   out_hop_o;
  logic [DW-1:0] out_data_o;
  logic [CW-1:0] miss_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  hop_router #(.NUM_ING(NI), .TBL_DEPTH(DEPTH), .DATA_W(DW), .MISS_CNT_W(CW)) i_hop_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_ing_i(cfg_ing_i), .cfg_hop_i(cfg_hop_i), .cfg_vld_i(cfg_vld_i),
    .cfg_egr_i(cfg_egr_i), .cfg_new_hop_i(cfg_new_hop_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_ing_i(in_ing_i), .in_hop_i(in_hop_i),
    .in_last_i(in_last_i), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_egr_o(out_egr_o),
    .out_hop_o(out_hop_o), .out_last_o(out_last_o), .out_data_o(out_data_o),
    .miss_flag_o(miss_flag_o), .miss_cnt_o(miss_cnt_o)
  );

  int total = 0, bad = 0;

  typedef struct { int eg; int hop; int data; bit last; string tag; } exp_t;
  exp_t q[$];

  // reference tables and frame state
  bit    mv [NI][DEPTH];
  int    meg[NI][DEPTH];
  int    moh[NI][DEPTH];
  bit    m_mid = 0, m_drop = 0, m_flag = 0;
  int    m_eg = 0, m_oh = 0, m_cnt = 0;
  string cur_tag = "R2";

  // staging, copied onto the ports at the falling edge
  bit s_we = 0, s_cvld = 0, s_valid = 0, s_last = 0, rand_cfg = 0;
  int s_cing = 0, s_chop = 0, s_cegr = 0, s_cnh = 0, s_ing = 0, s_hop = 0, s_data = 0;
  int ready_pct = 100;
  bit acc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_hit(int ing, int hop);
    return (hop < DEPTH) && mv[ing][hop];
  endfunction

  task automatic step();
    bit ofire;
    @(negedge clk);
    cfg_we_i = s_we; cfg_vld_i = s_cvld; cfg_ing_i = 2'(s_cing); cfg_hop_i = 11'(s_chop);
    cfg_egr_i = 6'(s_cegr); cfg_new_hop_i = 11'(s_cnh);
    in_valid_i = s_valid; in_ing_i = 2'(s_ing); in_hop_i = 11'(s_hop);
    in_last_i = s_last; in_data_i = DW'(s_data);
    out_ready_i = (ready_pct >= 100) ? 1'b1 : (($urandom % 100) < ready_pct);
    #1;
    // state reached at the previous rising edge
    chk(out_valid_o == (q.size() != 0), "R10", "out_valid", out_valid_o, q.size() != 0);
    chk(int'(miss_cnt_o) == m_cnt, "R5", "miss_cnt", miss_cnt_o, m_cnt);
    chk(miss_flag_o == m_flag, "R5", "miss_flag", miss_flag_o, m_flag);
    chk(in_ready_o == !(out_valid_o && !out_ready_i), "R9", "in_ready", in_ready_o,
        !(out_valid_o && !out_ready_i));
    ofire = out_valid_o && out_ready_i;
    if (out_valid_o && q.size() != 0) begin
      chk(int'(out_egr_o) == q[0].eg, q[0].tag, "egress", out_egr_o, q[0].eg);
      chk(int'(out_hop_o) == q[0].hop, q[0].tag, "hop", out_hop_o, q[0].hop);
      chk(int'(out_data_o) == q[0].data, q[0].tag, "data", out_data_o, q[0].data);
      chk(out_last_o == q[0].last, q[0].tag, "last", out_last_o, q[0].last);
      if (ofire) void'(q.pop_front());
    end
    acc = in_valid_i && in_ready_o;
    if (acc) begin
      if (!m_mid) begin
        if (m_hit(s_ing, s_hop)) begin
          m_drop = 0; m_eg = meg[s_ing][s_hop]; m_oh = moh[s_ing][s_hop];
          q.push_back('{m_eg, m_oh, s_data, s_last, cur_tag});
        end else begin
          m_drop = 1; m_flag = 1;
          if (m_cnt < CMAX) m_cnt++;
        end
      end else if (!m_drop) begin
        q.push_back('{m_eg, m_oh, s_data, s_last, "R6"});
      end
      m_mid = !s_last;
    end
    // write applies after this cycle's lookup (R7)
    if (s_we && s_chop < DEPTH) begin
      mv[s_cing][s_chop] = s_cvld; meg[s_cing][s_chop] = s_cegr; moh[s_cing][s_chop] = s_cnh;
    end
    @(posedge clk);
  endtask

  task automatic cfg_write(int ing, int hop, int eg, int nh, bit v);
    s_we = 1; s_cing = ing; s_chop = hop; s_cegr = eg; s_cnh = nh; s_cvld = v;
    step();
    s_we = 0;
  endtask

  task automatic send_pkt(int ing, int hop, int nb);
    for (int b = 0; b < nb; b++) begin
      s_valid = 1;
      s_ing  = (b == 0) ? ing : int'($urandom % NI);
      s_hop  = (b == 0) ? hop : int'($urandom % 2048);
      s_last = (b == nb - 1);
      s_data = int'($urandom);
      do begin
        if (rand_cfg && ($urandom % 10 == 0)) begin
          s_we = 1; s_cing = int'($urandom % NI); s_chop = int'($urandom % (DEPTH + 4));
          s_cegr = int'($urandom % 64); s_cnh = int'($urandom % 2048); s_cvld = ($urandom % 4) != 0;
        end
        step();
        s_we = 0;
      end while (!acc);
    end
    s_valid = 0;
  endtask

  task automatic drain();
    int keep;
    keep = ready_pct;
    s_valid = 0; ready_pct = 100;
    repeat (4) step();
    ready_pct = keep;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'd7731));
    for (int i = 0; i < NI; i++)
      for (int j = 0; j < DEPTH; j++) begin mv[i][j] = 0; meg[i][j] = 0; moh[i][j] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(out_valid_o == 0, "R1", "out_valid", out_valid_o, 0);
    chk(in_ready_o == 1, "R1", "in_ready", in_ready_o, 1);
    chk(miss_flag_o == 0, "R1", "miss_flag", miss_flag_o, 0);
    chk(miss_cnt_o == 0, "R1", "miss_cnt", miss_cnt_o, 0);
    @(posedge clk);
    send_pkt(0, 8, 1);
    drain();
    chk(miss_cnt_o == 1, "R1", "first header dropped", miss_cnt_o, 1);

    // R3 shared HopIDs 8 and 9 resolve per adapter; R6 continuation beats
    cur_tag = "R3";
    cfg_write(0, 8, 5, 12, 1);
    cfg_write(1, 8, 9, 8, 1);
    cfg_write(0, 9, 3, 9, 1);
    cfg_write(2, 9, 33, 1500, 1);
    send_pkt(0, 8, 3);
    send_pkt(1, 8, 2);
    send_pkt(0, 9, 1);
    send_pkt(2, 9, 4);
    drain();

    // R7 write and header in the same cycle
    cur_tag = "R7";
    c0 = int'(miss_cnt_o);
    s_we = 1; s_cing = 2; s_chop = 3; s_cegr = 7; s_cnh = 30; s_cvld = 1;
    s_valid = 1; s_ing = 2; s_hop = 3; s_last = 1; s_data = 32'h1234;
    step();
    s_we = 0; s_valid = 0;
    chk(acc == 1, "R7", "accepted", acc, 1);
    drain();
    chk(int'(miss_cnt_o) == c0 + 1, "R7", "same-cycle header used old entry", miss_cnt_o, c0 + 1);
    send_pkt(2, 3, 2);
    drain();
    chk(int'(miss_cnt_o) == c0 + 1, "R7", "next header hits", miss_cnt_o, c0 + 1);

    // R8 overwrite then invalidate
    cur_tag = "R8";
    cfg_write(0, 8, 11, 40, 1);
    send_pkt(0, 8, 2);
    cfg_write(0, 8, 0, 0, 0);
    c0 = int'(miss_cnt_o);
    send_pkt(0, 8, 2);
    drain();
    chk(int'(miss_cnt_o) == c0 + 1, "R8", "invalidated entry drops", miss_cnt_o, c0 + 1);

    // R4 out-of-range HopID, multi-beat, dropped as a whole
    cur_tag = "R4";
    c0 = int'(miss_cnt_o);
    send_pkt(1, 200, 4);
    drain();
    chk(int'(miss_cnt_o) == c0 + 1, "R4", "one miss per packet", miss_cnt_o, c0 + 1);
    chk(q.size() == 0 && out_valid_o == 0, "R4", "nothing forwarded", out_valid_o, 0);

    // random traffic with back-pressure and interleaved writes
    cur_tag = "R2";
    for (int i = 0; i < NI; i++)
      for (int j = 0; j < DEPTH; j++)
        cfg_write(i, j, int'($urandom % 64), int'($urandom % 2048), ($urandom % 4) != 0);
    ready_pct = 60; rand_cfg = 1;
    for (int p = 0; p < 400; p++)
      send_pkt(int'($urandom % NI), int'($urandom % (DEPTH + 4)), int'($urandom % 4) + 1);
    rand_cfg = 0;
    drain();

    // R5 counter saturation
    cfg_write(3, 15, 0, 0, 0);
    ready_pct = 100;
    for (int p = 0; p < 300; p++) send_pkt(3, 15, 1);
    drain();
    chk(int'(miss_cnt_o) == CMAX, "R5", "counter saturates", miss_cnt_o, CMAX);
    chk(miss_flag_o == 1, "R5", "flag sticky", miss_flag_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule